// File: doc/BRIEF.md
# Counter-Mode Block Crypt Engine with Metadata-Resident Counters

This engine encrypts blocks written back to non-volatile main memory and decrypts blocks read from it, using counter mode. A one-time pad for each data beat of a 256-byte block comes from a keyed mixing pipeline. The pipeline takes the secret key, the block address, the block's write counter and the beat index. The engine XORs each pad with the data beat. The mixing function is a stand-in for a real cipher core, and the key is assumed to be managed elsewhere.

The counter has no array of its own. The deduplication controller keeps one 32-bit metadata word per address. For any address, only one of its forward-map slot and its inverse-map slot is in use, so the free slot holds this word. The word carries the identity-mapping flag in one bit and the counter in the other 31 bits. The controller hands the word in with each request.

For a write, the engine returns the word with the counter advanced, and the controller stores it back. For a read, pad generation starts as soon as the request is accepted. It runs while the memory fetch is in flight, so ciphertext that arrives later costs only a register and an XOR. A counter that has reached its all-ones value cannot be written again. Such a write is refused and a rekey request is raised.

Top module: `cm_crypt_engine`

## Requirements
- R1: After reset, `busy_o`, `meta_valid_o`, `rekey_req_o`, `din_ready_o`, `dout_valid_o` and `dout_last_o` are all 0.
- R2: The metadata word holds the identity flag in bit 0 and the counter in bits 31:1. When a write is accepted, `meta_valid_o` pulses for one cycle, in the cycle after the start edge. In that cycle `meta_o` equals {counter+1, flag} taken from `meta_i`.
- R3: The pad for beat k is computed in three steps. First, x = key ^ {addr[31:0], ctr[30:0], 1'b0} ^ (k << 56). Second, x is replaced three times by y ^ rotl13(y), where y = x + (key ^ C), using C = 64'h9E3779B97F4A7C15, 64'hC2B2AE3D27D4EB4F and 64'h165667B19E3779F9 in that order. Third, the result is the pad. A write uses the advanced counter; a read uses the counter as supplied.
- R4: The output beats come in beat order, 32 beats of 64 bits per block. Each beat is `din_data_i ^ pad(k)`. `dout_last_o` marks beat 31, and `busy_o` is 0 in that same cycle.
- R5: A read uses the counter from `meta_i` unchanged and never asserts `meta_valid_o`. Decrypting the ciphertext of a write, with the word that write returned, gives back the plaintext.
- R6: A write whose counter field is all ones is refused. `rekey_req_o` pulses for one cycle, `busy_o` and `meta_valid_o` stay 0, and no data is accepted. A read with an all-ones counter proceeds normally.
- R7: The pad for beat k is ready 4 edges after its issue, and beat k is issued k+1 edges after the start edge. Data supplied early therefore leaves at edge start+5+k at the earliest.
- R8: `start_i` while `busy_o` is 1 has no effect: no metadata pulse and no change to the running block's counter, address or output.
- R9: Each accepted beat waits in a single holding register until its pad is ready. `din_ready_o` is 0 while a held beat cannot leave. A beat accepted at edge a leaves at edge max(a+1, start+5+k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_i | input | 64 | Secret key, stable while busy |
| start_i | input | 1 | Request start, taken only when idle |
| op_write_i | input | 1 | 1 = write (encrypt), 0 = read (decrypt) |
| addr_i | input | 32 | Block address |
| meta_i | input | 32 | Current metadata word {counter, identity flag} |
| busy_o | output | 1 | A block is in progress |
| meta_valid_o | output | 1 | Updated metadata word valid (writes only) |
| meta_o | output | 32 | Updated metadata word |
| rekey_req_o | output | 1 | Write refused: counter exhausted |
| din_valid_i | input | 1 | Input beat valid |
| din_data_i | input | 64 | Plaintext (write) or ciphertext (read) beat |
| din_ready_o | output | 1 | Input beat accepted on this edge |
| dout_valid_o | output | 1 | Output beat valid |
| dout_data_o | output | 64 | Ciphertext (write) or plaintext (read) beat |
| dout_last_o | output | 1 | Final beat of the block |

## Verification
Writes are swept over three addresses, including the top block of the address space, and three counter values, including the one just below wrap. The identity flag alternates across these runs. Checking every output beat against a model of the pad tells apart errors in address, counter and beat-index placement and in the round constants. Each ciphertext is read back with the returned word, both with data streamed in every cycle and with data trickling in after gaps; this separates the pad-ready latency from the holding-register latency through an exact edge count per beat. Three single cases complete the runs: an exhausted-counter write, a read at the counter ceiling, and a start pulse in the middle of a block. They separate refusal, read permissiveness and busy gating.

// File: rtl/cm_crypt_pkg.sv
package cm_crypt_pkg;
  localparam int ADDR_W = 32;
  localparam int META_W = 32;
  localparam int CTR_W  = META_W - 1;
  localparam int KEY_W  = 64;
  localparam int DATA_W = 64;
  localparam int NROUND = 3;

  function automatic logic [DATA_W-1:0] round_const(input int unsigned r);
    case (r)
      1:       return 64'h9E37_79B9_7F4A_7C15;
      2:       return 64'hC2B2_AE3D_27D4_EB4F;
      default: return 64'h1656_67B1_9E37_79F9;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pad_seed(
    input logic [KEY_W-1:0]  key,
    input logic [ADDR_W-1:0] addr,
    input logic [CTR_W-1:0]  ctr,
    input logic [7:0]        idx
  );
    return key ^ {addr, ctr, 1'b0} ^ {idx, 56'h0};
  endfunction

  function automatic logic [DATA_W-1:0] pad_round(
    input logic [DATA_W-1:0] x,
    input logic [KEY_W-1:0]  key,
    input logic [DATA_W-1:0] rc
  );
    logic [DATA_W-1:0] y;
    y = x + (key ^ rc);
    return y ^ {y[DATA_W-14:0], y[DATA_W-1:DATA_W-13]};
  endfunction
endpackage

// File: rtl/cm_meta_upd.sv
module cm_meta_upd
  import cm_crypt_pkg::*;
(
  input  logic [META_W-1:0] meta_i,
  output logic [CTR_W-1:0]  ctr_cur_o,
  output logic [CTR_W-1:0]  ctr_next_o,
  output logic              wrap_o,
  output logic [META_W-1:0] meta_next_o
);
  logic flag;

  always_comb begin
    ctr_cur_o   = meta_i[META_W-1:1];
    flag        = meta_i[0];
    wrap_o      = &ctr_cur_o;
    ctr_next_o  = ctr_cur_o + CTR_W'(1);
    meta_next_o = {ctr_next_o, flag};
  end
endmodule

// File: rtl/cm_pad_pipe.sv
module cm_pad_pipe
  import cm_crypt_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTR_W-1:0]  ctr_i,
  output logic              pad_wr_o,
  output logic [IDX_W-1:0]  pad_idx_o,
  output logic [DATA_W-1:0] pad_o
);
  // stages 0..NROUND-1 are registered, final round feeds the buffer write
  logic [DATA_W-1:0] st_q  [NROUND];
  logic              vld_q [NROUND];
  logic [IDX_W-1:0]  idx_q [NROUND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0] <= 1'b0;
      idx_q[0] <= '0;
      st_q[0]  <= '0;
    end else begin
      vld_q[0] <= issue_i;
      idx_q[0] <= idx_i;
      st_q[0]  <= pad_seed(key_i, addr_i, ctr_i, 8'(idx_i));
    end
  end

  for (genvar g = 1; g < NROUND; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        idx_q[g] <= '0;
        st_q[g]  <= '0;
      end else begin
        vld_q[g] <= vld_q[g-1];
        idx_q[g] <= idx_q[g-1];
        st_q[g]  <= pad_round(st_q[g-1], key_i, round_const(g));
      end
    end
  end

  assign pad_wr_o  = vld_q[NROUND-1];
  assign pad_idx_o = idx_q[NROUND-1];
  assign pad_o     = pad_round(st_q[NROUND-1], key_i, round_const(NROUND));
endmodule

// File: rtl/cm_pad_buf.sv
module cm_pad_buf
  import cm_crypt_pkg::*;
#(
  parameter int BEATS = 32,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_pad_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_pad_o
);
  logic              vld_q [BEATS];
  logic [DATA_W-1:0] pad_q [BEATS];

  for (genvar i = 0; i < BEATS; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i] <= 1'b0;
        pad_q[i] <= '0;
      end else if (clr_i) begin
        vld_q[i] <= 1'b0;
      end else if (wr_i && wr_idx_i == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        pad_q[i] <= wr_pad_i;
      end
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_pad_o = pad_q[rd_idx_i];
endmodule

// File: rtl/cm_crypt_engine.sv
module cm_crypt_engine
  import cm_crypt_pkg::*;
#(
  parameter int BLOCK_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              start_i,
  input  logic              op_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [META_W-1:0] meta_i,
  output logic              busy_o,
  output logic              meta_valid_o,
  output logic [META_W-1:0] meta_o,
  output logic              rekey_req_o,
  input  logic              din_valid_i,
  input  logic [DATA_W-1:0] din_data_i,
  output logic              din_ready_o,
  output logic              dout_valid_o,
  output logic [DATA_W-1:0] dout_data_o,
  output logic              dout_last_o
);
  localparam int BEATS = BLOCK_BYTES * 8 / DATA_W;
  localparam int IDX_W = $clog2(BEATS);
  localparam int CNT_W = IDX_W + 1;

  logic [CTR_W-1:0]  ctr_cur, ctr_next, ctr_q;
  logic              wrap;
  logic [META_W-1:0] meta_next, meta_q;
  logic [ADDR_W-1:0] addr_q;
  logic              busy_q, meta_valid_q, rekey_q;
  logic              iss_on_q;
  logic [IDX_W-1:0]  iss_cnt_q;
  logic [CNT_W-1:0]  din_cnt_q;
  logic              hold_full_q;
  logic [IDX_W-1:0]  hold_idx_q;
  logic [DATA_W-1:0] hold_q;
  logic              dout_valid_q, dout_last_q;
  logic [DATA_W-1:0] dout_q;

  logic              pad_wr, pad_rd_vld;
  logic [IDX_W-1:0]  pad_wr_idx;
  logic [DATA_W-1:0] pad_wr_data, pad_rd;
  logic              accept, fire, din_take, din_done;

  cm_meta_upd u_meta (
    .meta_i      (meta_i),
    .ctr_cur_o   (ctr_cur),
    .ctr_next_o  (ctr_next),
    .wrap_o      (wrap),
    .meta_next_o (meta_next)
  );

  cm_pad_pipe #(.IDX_W(IDX_W)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (iss_on_q),
    .idx_i     (iss_cnt_q),
    .key_i     (key_i),
    .addr_i    (addr_q),
    .ctr_i     (ctr_q),
    .pad_wr_o  (pad_wr),
    .pad_idx_o (pad_wr_idx),
    .pad_o     (pad_wr_data)
  );

  cm_pad_buf #(.BEATS(BEATS)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .wr_i     (pad_wr),
    .wr_idx_i (pad_wr_idx),
    .wr_pad_i (pad_wr_data),
    .rd_idx_i (hold_idx_q),
    .rd_vld_o (pad_rd_vld),
    .rd_pad_o (pad_rd)
  );

  assign accept      = start_i && !busy_q && !(op_write_i && wrap);
  assign fire        = hold_full_q && pad_rd_vld;
  assign din_done    = din_cnt_q == CNT_W'(BEATS);
  assign din_ready_o = busy_q && !din_done && (!hold_full_q || fire);
  assign din_take    = din_valid_i && din_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      meta_valid_q <= 1'b0;
      meta_q       <= '0;
      rekey_q      <= 1'b0;
      ctr_q        <= '0;
      addr_q       <= '0;
      iss_on_q     <= 1'b0;
      iss_cnt_q    <= '0;
      din_cnt_q    <= '0;
      hold_full_q  <= 1'b0;
      hold_idx_q   <= '0;
      hold_q       <= '0;
      dout_valid_q <= 1'b0;
      dout_last_q  <= 1'b0;
      dout_q       <= '0;
    end else begin
      meta_valid_q <= 1'b0;
      rekey_q      <= start_i && !busy_q && op_write_i && wrap;
      dout_valid_q <= 1'b0;
      dout_last_q  <= 1'b0;

      if (accept) begin
        busy_q       <= 1'b1;
        iss_on_q     <= 1'b1;
        iss_cnt_q    <= '0;
        din_cnt_q    <= '0;
        addr_q       <= addr_i;
        ctr_q        <= op_write_i ? ctr_next : ctr_cur;
        meta_valid_q <= op_write_i;
        if (op_write_i) meta_q <= meta_next;
      end

      if (iss_on_q) begin
        iss_cnt_q <= iss_cnt_q + IDX_W'(1);
        if (iss_cnt_q == IDX_W'(BEATS - 1)) iss_on_q <= 1'b0;
      end

      if (din_take) begin
        hold_q      <= din_data_i;
        hold_idx_q  <= din_cnt_q[IDX_W-1:0];
        din_cnt_q   <= din_cnt_q + CNT_W'(1);
        hold_full_q <= 1'b1;
      end else if (fire) begin
        hold_full_q <= 1'b0;
      end

      if (fire) begin
        dout_valid_q <= 1'b1;
        dout_q       <= hold_q ^ pad_rd;
        if (hold_idx_q == IDX_W'(BEATS - 1)) begin
          dout_last_q <= 1'b1;
          busy_q      <= 1'b0;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign meta_valid_o = meta_valid_q;
  assign meta_o       = meta_q;
  assign rekey_req_o  = rekey_q;
  assign dout_valid_o = dout_valid_q;
  assign dout_data_o  = dout_q;
  assign dout_last_o  = dout_last_q;
endmodule

// File: rtl/cm_crypt_engine_chk.sv
module cm_crypt_engine_chk
  import cm_crypt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              op_write_i,
  input logic [META_W-1:0] meta_i,
  input logic              busy_o,
  input logic              meta_valid_o,
  input logic [META_W-1:0] meta_o,
  input logic              rekey_req_o,
  input logic              din_ready_o,
  input logic              dout_valid_o,
  input logic              dout_last_o
);
  assert_meta_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_o |-> meta_o == {$past(meta_i[META_W-1:1]) + CTR_W'(1), $past(meta_i[0])});

  assert_meta_on_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meta_valid_o |-> $past(start_i && op_write_i && !busy_o));

  assert_refuse_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rekey_req_o |-> !busy_o && !meta_valid_o);

  assert_refuse_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rekey_req_o |-> $past(op_write_i) && (&$past(meta_i[META_W-1:1])));

  assert_last_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_last_o |-> dout_valid_o && !busy_o);

  assert_busy_from_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_start_busy_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> !meta_valid_o && !rekey_req_o);

  assert_ready_only_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_ready_o |-> busy_o);
endmodule

bind cm_crypt_engine cm_crypt_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .op_write_i   (op_write_i),
  .meta_i       (meta_i),
  .busy_o       (busy_o),
  .meta_valid_o (meta_valid_o),
  .meta_o       (meta_o),
  .rekey_req_o  (rekey_req_o),
  .din_ready_o  (din_ready_o),
  .dout_valid_o (dout_valid_o),
  .dout_last_o  (dout_last_o)
);

// File: tb/cm_crypt_engine_tb.sv
module cm_crypt_engine_tb;
  localparam int BEATS = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] key_i = '0;
  logic        start_i = 1'b0, op_write_i = 1'b0;
  logic [31:0] addr_i = '0, meta_i = '0;
  logic        busy_o, meta_valid_o, rekey_req_o;
  logic [31:0] meta_o;
  logic        din_valid_i = 1'b0;
  logic [63:0] din_data_i = '0;
  logic        din_ready_o, dout_valid_o, dout_last_o;
  logic [63:0] dout_data_o;

  cm_crypt_engine u_dut (.*, .clk_i(clk));

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0, edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  logic [63:0] din_arr [BEATS];
  logic [63:0] dout_arr[BEATS];
  int          acc_edge[BEATS];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mixr(input logic [63:0] x, input logic [63:0] k, input logic [63:0] c);
    logic [63:0] y;
    y = x + (k ^ c);
    return y ^ ((y << 13) | (y >> 51));
  endfunction

  function automatic logic [63:0] ref_pad(input logic [63:0] k, input logic [31:0] a,
                                          input logic [30:0] c, input int b);
    logic [63:0] x;
    x = k ^ {a, c, 1'b0} ^ (64'(b) << 56);
    x = mixr(x, k, 64'h9E37_79B9_7F4A_7C15);
    x = mixr(x, k, 64'hC2B2_AE3D_27D4_EB4F);
    x = mixr(x, k, 64'h1656_67B1_9E37_79F9);
    return x;
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // one block operation; checks R2..R5, R7..R9
  task automatic run_op(input bit wr, input logic [31:0] addr, input logic [31:0] meta,
                        input logic [63:0] key, input int gap, input bit mid_start);
    int s_edge;
    logic [30:0] ctr_use;
    ctr_use = wr ? meta[31:1] + 31'd1 : meta[31:1];
    @(negedge clk);
    key_i = key; start_i = 1'b1; op_write_i = wr; addr_i = addr; meta_i = meta;
    s_edge = edge_cnt + 1;
    @(negedge clk);
    start_i = 1'b0;
    if (wr) begin
      chk(meta_valid_o === 1'b1, "R2 meta_valid", 64'(meta_valid_o), 64'd1);
      chk(meta_o === {meta[31:1] + 31'd1, meta[0]}, "R2 meta word", 64'(meta_o),
          64'({meta[31:1] + 31'd1, meta[0]}));
    end else begin
      chk(meta_valid_o === 1'b0, "R5 no meta on read", 64'(meta_valid_o), 64'd0);
    end
    fork
      begin : drv
        for (int k = 0; k < BEATS; k++) begin
          bit ok;
          if (gap > 0) begin
            din_valid_i = 1'b0;
            repeat (gap) @(negedge clk);
          end
          din_valid_i = 1'b1;
          din_data_i  = din_arr[k];
          ok = 1'b0;
          while (!ok) begin
            #1 ok = din_ready_o;
            if (ok) acc_edge[k] = edge_cnt + 1;
            @(negedge clk);
          end
        end
        din_valid_i = 1'b0;
      end
      begin : col
        for (int k = 0; k < BEATS; k++) begin
          int exp_e;
          logic [63:0] exp_d;
          do @(negedge clk); while (!dout_valid_o);
          exp_d = din_arr[k] ^ ref_pad(key, addr, ctr_use, k);
          chk(dout_data_o === exp_d, wr ? "R3 R4 cipher beat" : "R3 R5 plain beat", dout_data_o, exp_d);
          exp_e = (acc_edge[k] + 1 > s_edge + 5 + k) ? acc_edge[k] + 1 : s_edge + 5 + k;
          chk(edge_cnt == exp_e, "R7 R9 beat edge", 64'(edge_cnt), 64'(exp_e));
          chk(dout_last_o === (k == BEATS - 1), "R4 last flag", 64'(dout_last_o), 64'(k == BEATS - 1));
          dout_arr[k] = dout_data_o;
        end
        chk(busy_o === 1'b0, "R4 idle after last", 64'(busy_o), 64'd0);
      end
      begin : mid
        if (mid_start) begin
          repeat (3) @(negedge clk);
          start_i = 1'b1; op_write_i = 1'b1; addr_i = ~addr; meta_i = 32'h0000_0042;
          @(negedge clk);
          start_i = 1'b0;
          chk(meta_valid_o === 1'b0, "R8 start while busy", 64'(meta_valid_o), 64'd0);
        end
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] addrs[3];
    logic [30:0] ctrs[3];
    addrs = '{32'h0000_0100, 32'hFFFF_FF00, 32'h1234_5600};
    ctrs  = '{31'd0, 31'd5, 31'h7FFF_FFFE};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o === 1'b0, "R1 busy", 64'(busy_o), 0);
    chk(meta_valid_o === 1'b0, "R1 meta_valid", 64'(meta_valid_o), 0);
    chk(rekey_req_o === 1'b0, "R1 rekey", 64'(rekey_req_o), 0);
    chk(din_ready_o === 1'b0, "R1 din_ready", 64'(din_ready_o), 0);
    chk(dout_valid_o === 1'b0, "R1 dout_valid", 64'(dout_valid_o), 0);
    chk(dout_last_o === 1'b0, "R1 dout_last", 64'(dout_last_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy after release", 64'(busy_o), 0);

    // sweep: write then read back, streamed and gapped
    for (int ia = 0; ia < 3; ia++) begin
      for (int ic = 0; ic < 3; ic++) begin
        logic [63:0] key;
        logic [31:0] meta;
        bit          flag;
        key  = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(ia) << 40) ^ 64'(ic * 7);
        flag = (ia + ic) % 2;
        meta = {ctrs[ic], flag};
        for (int k = 0; k < BEATS; k++)
          din_arr[k] = {addrs[ia], 24'h5A_C3_00, 8'(k)} ^ 64'hA5A5_0F0F_3C3C_5A5A ^ 64'(ic << 20);
        run_op(1'b1, addrs[ia], meta, key, 0, 1'b0);
        for (int k = 0; k < BEATS; k++) begin
          logic [63:0] pt;
          pt = din_arr[k];
          din_arr[k] = dout_arr[k];
          dout_arr[k] = pt;
        end
        // din_arr now holds ciphertext, dout_arr the plaintext
        begin
          logic [63:0] pt_save[BEATS];
          for (int k = 0; k < BEATS; k++) pt_save[k] = dout_arr[k];
          run_op(1'b0, addrs[ia], {meta[31:1] + 31'd1, flag}, key, (ic == 1) ? 3 : 0, 1'b0);
          for (int k = 0; k < BEATS; k++)
            chk(dout_arr[k] === pt_save[k], "R5 roundtrip", dout_arr[k], pt_save[k]);
        end
      end
    end

    // R6 exhausted counter on write is refused
    @(negedge clk);
    start_i = 1'b1; op_write_i = 1'b1; addr_i = 32'h0000_0200; meta_i = {31'h7FFF_FFFF, 1'b1};
    @(negedge clk);
    start_i = 1'b0;
    chk(rekey_req_o === 1'b1, "R6 rekey pulse", 64'(rekey_req_o), 1);
    chk(busy_o === 1'b0, "R6 stays idle", 64'(busy_o), 0);
    chk(meta_valid_o === 1'b0, "R6 no meta", 64'(meta_valid_o), 0);
    chk(din_ready_o === 1'b0, "R6 no data taken", 64'(din_ready_o), 0);
    @(negedge clk);
    chk(rekey_req_o === 1'b0, "R6 pulse one cycle", 64'(rekey_req_o), 0);

    // R6 read at the counter ceiling proceeds
    for (int k = 0; k < BEATS; k++) din_arr[k] = 64'hDEAD_BEEF_0000_0000 | 64'(k * 3);
    run_op(1'b0, 32'h0000_0200, {31'h7FFF_FFFF, 1'b0}, 64'h1122_3344_5566_7788, 1, 1'b0);

    // R8 start during a busy block does not disturb it
    for (int k = 0; k < BEATS; k++) din_arr[k] = {32'(k), 32'hCAFE_F00D};
    run_op(1'b1, 32'h0000_4400, {31'd9, 1'b0}, 64'h8765_4321_0FED_CBA9, 0, 1'b1);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule